// File: doc/BRIEF.md
# Multiplexed PC-Card Bus Master

This block turns one processor read or write request into a short burst of beats on a shared 16-bit bus. The burst goes to one of two external PC-card controllers. The request carries a 32-bit address, a byte-or-word flag, a read/write flag and a 32-bit write word. The top address nibble picks one of two device windows, and each window has its own enable bit. For an accepted request, one active-low select is asserted. Two address beats then go out: a header beat and the low address half. Two data beats follow, either driven for a write or captured from the bus for a read.

Reads of card space (attribute, I/O or common memory) hold the select and wait for the addressed controller's ready line before data is captured. Reads of controller registers and all writes run at full speed. Completion is a one-cycle done pulse. For reads, the assembled word is presented alongside that pulse. A request that falls in no enabled window completes at once, with no select and a zero result.

Top module: `pcc_mux_master`

## Requirements
- R1: Address bits 31:28 equal to 4 select device 0 (`sel_n[0]` low), and 5 selects device 1 (`sel_n[1]` low), but only when that device's `win_en` bit is 1. Any other request drives no select, pulses `rsp_done` in the cycle after acceptance, and returns `rsp_rdata` of 0. At most one select is low at any time.
- R2: In the first cycle after acceptance, the select is low, `bus_oe` is 1 and `bus_out` carries `{addr[25:16], size, addr[27:26], 2'b11}`. Here size is 2'b11 for a word access and 2'b00 for a byte access.
- R3: `xfer_type` is 0 for a write and 1 for a read during the header beat. It is 1 in every other cycle, including the second address beat.
- R4: In the second cycle after acceptance, `bus_out` carries `addr[15:0]` with `bus_oe` 1.
- R5: A write drives two more beats with `bus_oe` 1: first `wdata[31:16]`, then `wdata[15:0]`. Ready inputs are ignored.
- R6: A read with `addr[27:26]` = 2'b11 (controller registers) releases the bus (`bus_oe` 0) right after the address beats. It samples `bus_in` for two cycles, upper half first, without waiting for ready.
- R7: A read of card space (`addr[27:26]` of 00 attribute, 01 I/O, 10 common) keeps the select low and `bus_oe` 0 while the addressed device's `rdy` bit is 0. The other device's `rdy` has no effect. After the addressed bit is seen high, two capture cycles follow, upper half first.
- R8: `rsp_done` is a single-cycle pulse in the cycle after the last beat, with both selects high. After a read, `rsp_rdata` holds the captured word.
- R9: `req_ready` is 1 only when idle. Requests and changes to request inputs during a transaction have no effect on it, and the selects stay high for at least one cycle between transactions.
- R10: During reset, both selects are high, `bus_oe` is 0, `rsp_done` is 0, `xfer_type` is 1 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Processor address |
| req_word | input | 1 | 1 = 4-byte access, 0 = single byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| win_en | input | 2 | Per-device window enable |
| bus_oe | output | 1 | Shared bus output enable |
| bus_out | output | 16 | Shared bus driven value |
| bus_in | input | 16 | Shared bus received value |
| sel_n | output | 2 | Active-low device selects |
| xfer_type | output | 1 | Transfer-type line |
| rdy | input | 2 | Per-device ready |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read result |

## Verification
The assertions assume that `win_en` is stable for the whole of a transaction. They also assume that a controller raises its ready line only while it is being waited on, and that the ready line is not left asserted at the start of a later read. The stimulus changes `win_en` only while the block is idle. It raises the addressed ready bit for exactly one cycle at the end of a chosen wait and drops it again on the first capture beat. The unaddressed device's ready bit is pulsed during waits only to show that it is ignored. Request inputs are deliberately scrambled while a transaction is in flight.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_ALO, ST_DHI, ST_DLO, ST_WAIT, ST_RHI, ST_RLO, ST_END
  } pcc_state_e;

  localparam logic [1:0] SPACE_REGS = 2'b11;
  localparam logic [1:0] SLOT_CODE  = 2'b11;
  localparam logic [1:0] SIZE_WORD  = 2'b11;
  localparam logic [1:0] SIZE_BYTE  = 2'b00;
endpackage

// File: rtl/pcc_win_decode.sv
module pcc_win_decode #(
  parameter int NUM_DEV = 2,
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] BASE_NIB = 4'h4,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NIB_W-1:0]   region,
  input  logic [NUM_DEV-1:0] en,
  output logic               hit,
  output logic [DEV_W-1:0]   dev
);
  logic [NUM_DEV-1:0] match;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_match
    localparam logic [NIB_W-1:0] MY_NIB = BASE_NIB + NIB_W'(g);
    assign match[g] = (region == MY_NIB);
  end

  always_comb begin
    hit = 1'b0;
    dev = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (match[i]) begin
        hit = en[i];
        dev = DEV_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcc_beat_fsm.sv
module pcc_beat_fsm
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       hit,
  input  logic       is_write,
  input  logic       is_reg,
  input  logic       dev_ready,
  output pcc_state_e state
);
  pcc_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (accept) state_nxt = hit ? ST_HDR : ST_END;
      ST_HDR:  state_nxt = ST_ALO;
      ST_ALO:  state_nxt = is_write ? ST_DHI : (is_reg ? ST_RHI : ST_WAIT);
      ST_DHI:  state_nxt = ST_DLO;
      ST_DLO:  state_nxt = ST_END;
      ST_WAIT: if (dev_ready) state_nxt = ST_RHI;
      ST_RHI:  state_nxt = ST_RLO;
      ST_RLO:  state_nxt = ST_END;
      ST_END:  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !dev_ready) |=> (state == ST_WAIT)); // R7
  AST_WRITE_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DHI) |=> (state == ST_DLO)); // R5
endmodule

// File: rtl/pcc_rd_capture.sv
module pcc_rd_capture #(
  parameter int BUS_W = 16,
  localparam int DATA_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [DATA_W-1:0] rdata
);
  logic [BUS_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_q <= '0;
    else if (clr || cap_hi) hi_q <= clr ? '0 : bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lo_q <= '0;
    else if (clr || cap_lo) lo_q <= clr ? '0 : bus_in;
  end

  assign rdata = {hi_q, lo_q};
endmodule

// File: rtl/pcc_mux_master.sv
module pcc_mux_master
  import pcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BUS_W   = 16,
  parameter int CARD_AW = 26,
  parameter int NUM_DEV = 2,
  parameter logic [3:0] BASE_NIB = 4'h4,
  localparam int DATA_W = 2 * BUS_W,
  localparam int HDR_W  = 6,
  localparam int HI_AW  = BUS_W - HDR_W,
  localparam int KEEP_W = CARD_AW + 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_word,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NUM_DEV-1:0] win_en,
  output logic               bus_oe,
  output logic [BUS_W-1:0]   bus_out,
  input  logic [BUS_W-1:0]   bus_in,
  output logic [NUM_DEV-1:0] sel_n,
  output logic               xfer_type,
  input  logic [NUM_DEV-1:0] rdy,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  pcc_state_e          state;
  logic                accept, hit, busy, sel_act;
  logic [DEV_W-1:0]    dev_c, dev_q;
  logic [KEEP_W-1:0]   addr_q;
  logic                word_q, wr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [1:0]          space_q, size_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;

  pcc_win_decode #(.NUM_DEV(NUM_DEV), .NIB_W(4), .BASE_NIB(BASE_NIB)) u_dec (
    .region (req_addr[ADDR_W-1 -: 4]),
    .en     (win_en),
    .hit    (hit),
    .dev    (dev_c)
  );

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      dev_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr[KEEP_W-1:0];
      word_q  <= req_word;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
      dev_q   <= dev_c;
    end
  end

  assign space_q = addr_q[CARD_AW +: 2];
  assign size_q  = word_q ? SIZE_WORD : SIZE_BYTE;

  pcc_beat_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .accept    (accept),
    .hit       (hit),
    .is_write  (wr_q),
    .is_reg    (space_q == SPACE_REGS),
    .dev_ready (rdy[dev_q]),
    .state     (state)
  );

  pcc_rd_capture #(.BUS_W(BUS_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (accept),
    .cap_hi (state == ST_RHI),
    .cap_lo (state == ST_RLO),
    .bus_in (bus_in),
    .rdata  (rsp_rdata)
  );

  assign busy = state inside {ST_HDR, ST_ALO, ST_DHI, ST_DLO, ST_WAIT, ST_RHI, ST_RLO};

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
    assign sel_n[g] = !(busy && (dev_q == DEV_W'(g)));
  end
  assign sel_act = ~&sel_n;

  always_comb begin
    bus_out = '0;
    bus_oe  = 1'b1;
    unique case (state)
      ST_HDR:  bus_out = {addr_q[CARD_AW-1 -: HI_AW], size_q, space_q, SLOT_CODE};
      ST_ALO:  bus_out = addr_q[BUS_W-1:0];
      ST_DHI:  bus_out = wdata_q[DATA_W-1 -: BUS_W];
      ST_DLO:  bus_out = wdata_q[BUS_W-1:0];
      default: bus_oe  = 1'b0;
    endcase
  end

  assign xfer_type = (state == ST_HDR) ? !wr_q : 1'b1;
  assign rsp_done  = (state == ST_END);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(~sel_n)); // R1
  AST_DRIVE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_oe |-> sel_act); // R2
  AST_SECOND_BEAT_TYPE_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_act && $past(sel_act) && !$past(sel_act, 2)) |-> xfer_type); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |=> !rsp_done); // R8
  AST_DONE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |-> !sel_act); // R8
  AST_SELECT_GAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sel_act && $past(sel_act)) |=> !sel_act); // R9
endmodule

// File: tb/tb_pcc_mux_master.sv
module tb_pcc_mux_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_word, req_write;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic [1:0]  win_en, sel_n, rdy;
  logic        bus_oe, xfer_type, rsp_done;
  logic [15:0] bus_out, bus_in;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcc_mux_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .win_en(win_en), .bus_oe(bus_oe), .bus_out(bus_out),
    .bus_in(bus_in), .sel_n(sel_n), .xfer_type(xfer_type), .rdy(rdy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        word;
    logic        wr;
    logic [31:0] wdata;
    logic [1:0]  en;
    logic [3:0]  dly;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h4A12_3456, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'b11, 4'd0, 32'h0},
    '{32'h5C00_0010, 1'b0, 1'b0, 32'h0,         2'b11, 4'd0, 32'h1234_ABCD},
    '{32'h4400_FF00, 1'b1, 1'b0, 32'h0,         2'b11, 4'd3, 32'hCAFE_F00D},
    '{32'h5000_0001, 1'b0, 1'b1, 32'h0000_00A5, 2'b11, 4'd0, 32'h0},
    '{32'h5800_1234, 1'b1, 1'b0, 32'h0,         2'b10, 4'd0, 32'h8765_4321},
    '{32'h4C00_0004, 1'b1, 1'b1, 32'h0BAD_F00D, 2'b01, 4'd0, 32'h0},
    '{32'h6000_0000, 1'b1, 1'b0, 32'h0,         2'b11, 4'd0, 32'h0},
    '{32'h4800_0000, 1'b1, 1'b1, 32'h1111_2222, 2'b10, 4'd0, 32'h0},
    '{32'h3FFF_FFFC, 1'b1, 1'b0, 32'h0,         2'b11, 4'd0, 32'h0},
    '{32'h5FFF_FFFE, 1'b0, 1'b0, 32'h0,         2'b10, 4'd5, 32'h55AA_33CC}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    logic       hit, dev;
    logic [1:0] exp_sel;
    logic [15:0] hdr;
    dev = (v.addr[31:28] == 4'h5);
    hit = (v.addr[31:28] == 4'h4 && v.en[0]) || (v.addr[31:28] == 4'h5 && v.en[1]);
    exp_sel = dev ? 2'b01 : 2'b10;
    hdr = {v.addr[25:16], (v.word ? 2'b11 : 2'b00), v.addr[27:26], 2'b11};

    @(negedge clk);
    win_en = v.en; req_addr = v.addr; req_word = v.word;
    req_write = v.wr; req_wdata = v.wdata; req_valid = 1'b1;
    check("R9 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    // scramble request inputs while busy (R9)
    req_addr = ~v.addr; req_wdata = ~v.wdata; req_write = ~v.wr; req_word = ~v.word;
    if (!hit) begin
      check("R1 unmapped done", 32'(rsp_done), 32'd1);
      check("R1 unmapped no select", 32'(sel_n), 32'h3);
      check("R1 unmapped rdata zero", rsp_rdata, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      check("R9 ready after unmapped", 32'(req_ready), 32'd1);
      return;
    end
    check("R1 select", 32'(sel_n), 32'(exp_sel));
    check("R2 header oe", 32'(bus_oe), 32'd1);
    check("R2 header beat", 32'(bus_out), 32'(hdr));
    check("R3 type in header", 32'(xfer_type), 32'(!v.wr));
    check("R9 not ready busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R4 low address beat", 32'(bus_out), 32'(v.addr[15:0]));
    check("R3 type high second beat", 32'(xfer_type), 32'd1);
    if (v.wr) begin
      @(negedge clk);
      check("R5 data hi", 32'(bus_out), 32'(v.wdata[31:16]));
      check("R5 oe hi", 32'(bus_oe), 32'd1);
      @(negedge clk);
      check("R5 data lo", 32'(bus_out), 32'(v.wdata[15:0]));
      check("R3 type high data", 32'(xfer_type), 32'd1);
    end else if (v.addr[27:26] == 2'b11) begin
      @(negedge clk);
      check("R6 bus released", 32'(bus_oe), 32'd0);
      bus_in = v.rd[31:16];
      @(negedge clk);
      check("R6 still selected", 32'(sel_n), 32'(exp_sel));
      bus_in = v.rd[15:0];
    end else begin
      for (int i = 0; i <= int'(v.dly); i++) begin
        @(negedge clk);
        check("R7 waiting oe low", 32'(bus_oe), 32'd0);
        check("R7 waiting selected", 32'(sel_n), 32'(exp_sel));
        check("R7 no done while waiting", 32'(rsp_done), 32'd0);
        rdy = 2'b00;
        if (i == int'(v.dly)) rdy[dev] = 1'b1;
        else                  rdy[!dev] = 1'b1;
      end
      @(negedge clk);
      rdy = 2'b00;
      bus_in = v.rd[31:16];
      @(negedge clk);
      bus_in = v.rd[15:0];
    end
    @(negedge clk);
    bus_in = 16'h0;
    check("R8 done pulse", 32'(rsp_done), 32'd1);
    check("R8 selects released", 32'(sel_n), 32'h3);
    if (!v.wr) check("R8 read word", rsp_rdata, v.rd);
    req_valid = 1'b0;
    @(negedge clk);
    check("R8 done single", 32'(rsp_done), 32'd0);
    check("R9 gap idle select", 32'(sel_n), 32'h3);
    check("R9 ready again", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
    req_write = 1'b0; req_wdata = '0; win_en = 2'b11; bus_in = '0; rdy = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 reset selects", 32'(sel_n), 32'h3);
    check("R10 reset oe", 32'(bus_oe), 32'd0);
    check("R10 reset done", 32'(rsp_done), 32'd0);
    check("R10 reset type", 32'(xfer_type), 32'd1);
    check("R10 reset rdata", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) run(VECS[k]);

    // reset in the middle of a write
    @(negedge clk);
    req_addr = 32'h4800_0100; req_word = 1'b1; req_write = 1'b1;
    req_wdata = 32'h7777_8888; win_en = 2'b11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 select before reset", 32'(sel_n), 32'h2);
    rst_n = 1'b0;
    #1;
    check("R10 reset drops select", 32'(sel_n), 32'h3);
    check("R10 reset drops oe", 32'(bus_oe), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle after reset", 32'(req_ready), 32'd1);

    // byte read of device 1 register space, back to back with a byte write
    run('{32'h5C12_3400, 1'b0, 1'b0, 32'h0, 2'b11, 4'd0, 32'hA5A5_5A5A});
    run('{32'h4000_0002, 1'b0, 1'b1, 32'h0000_00C3, 2'b01, 4'd0, 32'h0});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule